// File: doc/BRIEF.md
# Rendezvous Message Port Queue

This block is a hardware meeting point between tasks that produce message words and tasks that consume them. A single storage ring holds one kind of item at a time. Either it holds message words that no one has received yet, or it holds the identifiers of receivers that are waiting for a message. Commands arrive one per cycle on a valid/ready interface. Each command carries an operation code, the requester's identifier, a carrier identifier and a message word. One cycle after a command is accepted, the block returns a completed, blocked or failed status. A completed receive also returns the message word it took.

A send that finds receivers waiting does not store its message. It hands the message to the oldest waiter and reports that waiter on a wake-up output. A blocking send that finds the ring full of messages is parked in a small separate list of blocked senders. Each receive then frees one slot, and the oldest parked sender's message moves into the ring. That sender is announced on a release output. Conditional variants never wait. Surrogate variants make a carrier identifier wait in place of the requester. If the queued identifiers are treated as task identifiers, the same block can serve as a dispatch queue.

Top module: `rdv_port`

## Requirements
- R1: The ring holds only one kind of item at a time. Its kind can change only in a cycle that starts with the ring empty, so a send never stores a message while receivers are queued.
- R2: A blocking receive (op 1) that finds no stored message queues the requester's identifier as a waiter and answers BLOCKED. Status encodings are DONE=0, BLOCKED=1 and FAILED=2.
- R3: A blocking send (op 0) that finds the ring full of messages parks the requester with its message in the blocked-sender list and answers BLOCKED.
- R4: A conditional send (op 2) or conditional receive (op 3) never answers BLOCKED. It answers DONE when it can complete at once and FAILED otherwise, and a FAILED conditional changes nothing.
- R5: A surrogate send (op 4) or surrogate receive (op 5) behaves like its blocking form, except that the carrier identifier, not the requester's, is what waits. That carrier is the identifier later reported on the wake-up or release output.
- R6: Stored messages are received in the order they were stored, and queued waiters are served in the order they arrived.
- R7: A send that finds waiters queued answers DONE and stores nothing. In the next cycle it pulses the wake-up output with the oldest waiter's identifier and the sent message.
- R8: A receive that takes a message while senders are parked pulses the release output with the oldest parked sender. That sender's message joins the tail of the ring, so the ring stays full.
- R9: A blocking or surrogate command that would need a slot in a full ring (receive side) or in a full blocked-sender list (send side) answers FAILED and changes nothing.
- R10: Operation codes 6 and 7 answer FAILED and leave the stored contents unchanged.
- R11: The block accepts one command per cycle with cmd_ready high after reset. Exactly one response appears in the cycle after each accepted command, and none appears otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Operation code |
| cmd_id | input | IDW | Requester identifier |
| cmd_carrier | input | IDW | Carrier identifier for surrogate operations |
| cmd_msg | input | MW | Message word for sends |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | DONE, BLOCKED or FAILED |
| rsp_msg | output | MW | Message taken by a completed receive, else zero |
| wake_valid | output | 1 | A queued waiter was matched with a message |
| wake_id | output | IDW | Identifier of the woken waiter |
| wake_msg | output | MW | Message delivered to it |
| rel_valid | output | 1 | A parked sender was released |
| rel_id | output | IDW | Identifier of the released sender |

## Verification
The assertions check four things on every cycle. A response follows each accepted command, with none in other cycles. The item kind changes only after an empty ring. Senders stay parked only while the ring is full of messages. A conditional or invalid command never reports BLOCKED, and a wake-up always comes with a DONE answer. Only the bench's scenarios can show that message words and identifiers come out in arrival order and that the oldest waiter or parked sender is chosen. They are also needed to show that failed commands truly leave the contents alone. The bench shows this by comparing every answer, wake-up and release against its own queue model across a long patterned command sweep.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
  typedef enum logic [1:0] {
    ST_DONE    = 2'd0,
    ST_BLOCKED = 2'd1,
    ST_FAILED  = 2'd2
  } st_e;

  typedef enum logic [1:0] {
    SRC_MSG    = 2'd0,
    SRC_ID     = 2'd1,
    SRC_CAR    = 2'd2,
    SRC_PARKED = 2'd3
  } src_e;

  function automatic logic op_is_send(input logic [2:0] op);
    return (op == 3'd0) || (op == 3'd2) || (op == 3'd4);
  endfunction

  function automatic logic op_is_recv(input logic [2:0] op);
    return (op == 3'd1) || (op == 3'd3) || (op == 3'd5);
  endfunction

  function automatic logic op_is_cond(input logic [2:0] op);
    return (op == 3'd2) || (op == 3'd3);
  endfunction

  function automatic logic op_is_surr(input logic [2:0] op);
    return (op == 3'd4) || (op == 3'd5);
  endfunction
endpackage

// File: rtl/rdv_ring.sv
module rdv_ring #(
  parameter int W = 8,
  parameter int D = 4,
  localparam int AW = (D > 1) ? $clog2(D) : 1,
  localparam int CW = $clog2(D + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [D];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(D - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/rdv_decide.sv
module rdv_decide
  import rdv_pkg::*;
(
  input  logic       fire,
  input  logic [2:0] op,
  input  logic       q_waiters,
  input  logic       q_empty,
  input  logic       q_full,
  input  logic       bs_empty,
  input  logic       bs_full,
  output logic       q_push,
  output logic       q_pop,
  output src_e       q_src,
  output logic       bs_push,
  output logic       bs_use_car,
  output logic       bs_pop,
  output logic       wake,
  output logic       deliver,
  output logic       release_o,
  output st_e        status
);
  logic is_send, is_recv, is_cond, is_surr;

  always_comb begin
    is_send    = op_is_send(op);
    is_recv    = op_is_recv(op);
    is_cond    = op_is_cond(op);
    is_surr    = op_is_surr(op);
    q_push     = 1'b0;
    q_pop      = 1'b0;
    q_src      = SRC_MSG;
    bs_push    = 1'b0;
    bs_use_car = 1'b0;
    bs_pop     = 1'b0;
    wake       = 1'b0;
    deliver    = 1'b0;
    release_o  = 1'b0;
    status     = ST_FAILED;
    if (fire && is_send) begin
      if (q_waiters && !q_empty) begin
        q_pop  = 1'b1;
        wake   = 1'b1;
        status = ST_DONE;
      end else if (!q_full) begin
        q_push = 1'b1;
        q_src  = SRC_MSG;
        status = ST_DONE;
      end else if (!is_cond && !bs_full) begin
        bs_push    = 1'b1;
        bs_use_car = is_surr;
        status     = ST_BLOCKED;
      end
    end else if (fire && is_recv) begin
      if (!q_waiters && !q_empty) begin
        q_pop   = 1'b1;
        deliver = 1'b1;
        status  = ST_DONE;
        if (!bs_empty) begin
          bs_pop    = 1'b1;
          q_push    = 1'b1;
          q_src     = SRC_PARKED;
          release_o = 1'b1;
        end
      end else if (!is_cond && !q_full) begin
        q_push = 1'b1;
        q_src  = is_surr ? SRC_CAR : SRC_ID;
        status = ST_BLOCKED;
      end
    end
  end
endmodule

// File: rtl/rdv_port.sv
module rdv_port
  import rdv_pkg::*;
#(
  parameter int IDW   = 4,
  parameter int MW    = 8,
  parameter int DEPTH = 4,
  parameter int PARK  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [IDW-1:0] cmd_id,
  input  logic [IDW-1:0] cmd_carrier,
  input  logic [MW-1:0]  cmd_msg,
  output logic           rsp_valid,
  output logic [1:0]     rsp_status,
  output logic [MW-1:0]  rsp_msg,
  output logic           wake_valid,
  output logic [IDW-1:0] wake_id,
  output logic [MW-1:0]  wake_msg,
  output logic           rel_valid,
  output logic [IDW-1:0] rel_id
);
  localparam int EW  = (MW > IDW) ? MW : IDW;
  localparam int PW  = IDW + MW;
  localparam int QCW = $clog2(DEPTH + 1);
  localparam int PCW = $clog2(PARK + 1);

  logic           fire;
  logic           mode_q;
  logic [EW-1:0]  q_head, q_wdata;
  logic [QCW-1:0] q_count;
  logic [PW-1:0]  bs_head, bs_wdata;
  logic [PCW-1:0] bs_count;
  logic           q_push, q_pop, bs_push, bs_use_car, bs_pop;
  logic           wake, deliver, release_w;
  src_e           q_src;
  st_e            status;
  logic           q_empty, q_full, bs_empty, bs_full;

  assign fire     = cmd_valid && cmd_ready;
  assign q_empty  = (q_count == '0);
  assign q_full   = (q_count == QCW'(DEPTH));
  assign bs_empty = (bs_count == '0);
  assign bs_full  = (bs_count == PCW'(PARK));

  rdv_decide u_decide (
    .fire       (fire),
    .op         (cmd_op),
    .q_waiters  (mode_q),
    .q_empty    (q_empty),
    .q_full     (q_full),
    .bs_empty   (bs_empty),
    .bs_full    (bs_full),
    .q_push     (q_push),
    .q_pop      (q_pop),
    .q_src      (q_src),
    .bs_push    (bs_push),
    .bs_use_car (bs_use_car),
    .bs_pop     (bs_pop),
    .wake       (wake),
    .deliver    (deliver),
    .release_o  (release_w),
    .status     (status)
  );

  always_comb begin
    case (q_src)
      SRC_ID:     q_wdata = EW'(cmd_id);
      SRC_CAR:    q_wdata = EW'(cmd_carrier);
      SRC_PARKED: q_wdata = EW'(bs_head[MW-1:0]);
      default:    q_wdata = EW'(cmd_msg);
    endcase
  end

  assign bs_wdata = {(bs_use_car ? cmd_carrier : cmd_id), cmd_msg};

  rdv_ring #(.W(EW), .D(DEPTH)) u_items (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .pop   (q_pop),
    .wdata (q_wdata),
    .rdata (q_head),
    .count (q_count)
  );

  rdv_ring #(.W(PW), .D(PARK)) u_parked (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (bs_push),
    .pop   (bs_pop),
    .wdata (bs_wdata),
    .rdata (bs_head),
    .count (bs_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready  <= 1'b0;
      mode_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= 2'd0;
      rsp_msg    <= '0;
      wake_valid <= 1'b0;
      wake_id    <= '0;
      wake_msg   <= '0;
      rel_valid  <= 1'b0;
      rel_id     <= '0;
    end else begin
      cmd_ready  <= 1'b1;
      if (q_push && q_empty)
        mode_q <= (q_src == SRC_ID) || (q_src == SRC_CAR);
      rsp_valid  <= fire;
      rsp_status <= fire ? 2'(status) : 2'd0;
      rsp_msg    <= deliver ? q_head[MW-1:0] : '0;
      wake_valid <= wake;
      wake_id    <= wake ? q_head[IDW-1:0] : '0;
      wake_msg   <= wake ? cmd_msg : '0;
      rel_valid  <= release_w;
      rel_id     <= release_w ? bs_head[PW-1:MW] : '0;
    end
  end
endmodule

// File: rtl/rdv_port_chk.sv
module rdv_port_chk #(
  parameter int DEPTH = 4,
  parameter int QCW   = 3,
  parameter int PCW   = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [2:0]     cmd_op,
  input logic           rsp_valid,
  input logic [1:0]     rsp_status,
  input logic           wake_valid,
  input logic           mode_q,
  input logic [QCW-1:0] q_count,
  input logic [PCW-1:0] bs_count
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  // R11
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);
  // R1
  kind_flip_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(q_count) == '0));
  // R8
  parked_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_count != '0) |-> (q_count == QCW'(DEPTH) && !mode_q));
  // R4
  cond_never_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cmd_op == 3'd2 || cmd_op == 3'd3)) |=> (rsp_status != 2'd1));
  // R10
  bad_op_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op[2:1] == 2'b11) |=> (rsp_status == 2'd2));
  // R7
  wake_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (rsp_valid && rsp_status == 2'd0));
  // R9
  ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCW'(DEPTH));
endmodule

bind rdv_port rdv_port_chk #(.DEPTH(DEPTH), .QCW(QCW), .PCW(PCW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .wake_valid (wake_valid),
  .mode_q     (mode_q),
  .q_count    (q_count),
  .bs_count   (bs_count)
);

// File: tb/rdv_port_bench.sv
module rdv_port_bench;
  localparam int IDW = 4, MW = 8, DEPTH = 4, PARK = 2;

  logic           clk = 1'b0, rst_n = 1'b0;
  logic           cmd_valid = 1'b0, cmd_ready;
  logic [2:0]     cmd_op = '0;
  logic [IDW-1:0] cmd_id = '0, cmd_carrier = '0;
  logic [MW-1:0]  cmd_msg = '0;
  logic           rsp_valid, wake_valid, rel_valid;
  logic [1:0]     rsp_status;
  logic [MW-1:0]  rsp_msg, wake_msg;
  logic [IDW-1:0] wake_id, rel_id;

  int total = 0, bad = 0;
  int mq[$], pid[$], pmsg[$];
  bit mm = 0;

  always #4 clk = ~clk;

  rdv_port #(.IDW(IDW), .MW(MW), .DEPTH(DEPTH), .PARK(PARK)) u_rdv_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_carrier(cmd_carrier), .cmd_msg(cmd_msg),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_msg(rsp_msg),
    .wake_valid(wake_valid), .wake_id(wake_id), .wake_msg(wake_msg),
    .rel_valid(rel_valid), .rel_id(rel_id)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Queue model written from the requirements.
  task automatic model(input int op, input int id, input int car, input int msg,
                       output int st, output int rm, output int wk, output int wkid,
                       output int rl, output int rlid);
    bit snd = (op == 0 || op == 2 || op == 4);
    bit rcv = (op == 1 || op == 3 || op == 5);
    bit cnd = (op == 2 || op == 3);
    bit sur = (op == 4 || op == 5);
    st = 2; rm = 0; wk = 0; wkid = 0; rl = 0; rlid = 0;
    if (snd) begin
      if (mm && mq.size() > 0) begin wk = 1; wkid = mq.pop_front(); st = 0; end
      else if (mq.size() < DEPTH) begin
        if (mq.size() == 0) mm = 0;
        mq.push_back(msg); st = 0;
      end else if (!cnd && pid.size() < PARK) begin
        pid.push_back(sur ? car : id); pmsg.push_back(msg); st = 1;
      end
    end else if (rcv) begin
      if (!mm && mq.size() > 0) begin
        rm = mq.pop_front(); st = 0;
        if (pid.size() > 0) begin
          rl = 1; rlid = pid.pop_front(); mq.push_back(pmsg.pop_front());
        end
      end else if (!cnd && mq.size() < DEPTH) begin
        if (mq.size() == 0) mm = 1;
        mq.push_back(sur ? car : id); st = 1;
      end
    end
  endtask

  task automatic cmd(input int op, input int id, input int car, input int msg, input string tag);
    int st, rm, wk, wkid, rl, rlid;
    model(op, id, car, msg, st, rm, wk, wkid, rl, rlid);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_id = IDW'(id);
    cmd_carrier = IDW'(car); cmd_msg = MW'(msg);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " R11 rsp_valid"}, int'(rsp_valid), 1);
    chk(int'(rsp_status) == st, {tag, " status"}, int'(rsp_status), st);
    chk(int'(rsp_msg) == rm, {tag, " rsp_msg"}, int'(rsp_msg), rm);
    chk(int'(wake_valid) == wk, {tag, " wake_valid"}, int'(wake_valid), wk);
    if (wk != 0) begin
      chk(int'(wake_id) == wkid, {tag, " wake_id"}, int'(wake_id), wkid);
      chk(int'(wake_msg) == msg, {tag, " wake_msg"}, int'(wake_msg), msg);
    end
    chk(int'(rel_valid) == rl, {tag, " rel_valid"}, int'(rel_valid), rl);
    if (rl != 0) chk(int'(rel_id) == rlid, {tag, " rel_id"}, int'(rel_id), rlid);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", int'(rsp_valid), 0);
    chk(wake_valid == 1'b0 && rel_valid == 1'b0, "R11 reset wake/rel", int'(wake_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11 ready after reset", int'(cmd_ready), 1);

    // R2, R7, R6: waiters queue in order, sends wake them oldest first
    cmd(1, 1, 0, 0, "R2 recv empty");
    cmd(1, 2, 0, 0, "R2 recv empty");
    cmd(0, 5, 0, 8'hA1, "R7 send wakes oldest");
    cmd(0, 5, 0, 8'hA2, "R6 R7 second wake");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 idle no rsp", int'(rsp_valid), 0);

    // R1, R3, R5, R9, R4 on a full ring of messages
    for (int i = 0; i < DEPTH; i++) cmd(0, 3, 0, 16 + i, "R1 store msg");
    cmd(0, 3, 0, 8'h55, "R3 blocking send full");
    cmd(4, 7, 9, 8'h66, "R5 surrogate send full");
    cmd(0, 4, 0, 8'h77, "R9 park list full");
    cmd(2, 4, 0, 8'h78, "R4 cond send full");
    // R8, R6: receives drain in order and release parked senders
    for (int i = 0; i < DEPTH + PARK; i++) cmd(1, 8, 0, 0, "R8 R6 recv drain");

    // R4, R5 conditional and surrogate receives
    cmd(3, 2, 0, 0, "R4 cond recv empty");
    cmd(5, 2, 12, 0, "R5 surrogate recv");
    cmd(2, 6, 0, 8'h3C, "R4 R5 cond send wakes carrier");
    cmd(2, 6, 0, 8'h3D, "R4 cond send store");
    cmd(3, 6, 0, 0, "R4 cond recv done");

    // R10 invalid ops leave contents
    cmd(0, 1, 0, 8'h99, "R10 setup");
    cmd(6, 1, 1, 8'h11, "R10 op6");
    cmd(7, 1, 1, 8'h12, "R10 op7");
    cmd(1, 1, 0, 0, "R10 msg intact");

    // R9 waiter ring full
    for (int i = 0; i < DEPTH; i++) cmd(1, 10 + i, 0, 0, "R9 fill waiters");
    cmd(1, 15, 0, 0, "R9 waiter ring full");
    cmd(5, 15, 14, 0, "R9 surrogate ring full");
    for (int i = 0; i < DEPTH; i++) cmd(0, 1, 0, 40 + i, "R6 R7 wake in order");

    // Patterned sweep over all operation codes
    for (int i = 0; i < 600; i++)
      cmd((i * 5 + i / 4) % 8, i % 16, (i + 7) % 16, (i * 37) % 256, "R1 R6 sweep");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule